// File: doc/BRIEF.md
# Quadword Tagged Memory

This block is a small synchronous single-port memory. Every aligned 16-byte quadword carries a validity tag, which marks a 128-bit value as a trusted pointer. A caller sends one request per cycle on the request bus. Each request gives a byte address, an access size, a write enable, write data, a tag input and a checked-load flag.

Loads always fetch a full quadword. A quadword store writes all 128 bits and copies the tag input into the quadword's tag. Any narrower store (byte, halfword, word or doubleword) writes only its own byte lanes and always clears the tag of the quadword it touches. This means that editing any part of a stored pointer revokes its validity.

Internally each quadword holds one tag flop per `GRAN_BYTES` bytes. A load only ever reports the AND of those flops. A checked load returns all-zero data whenever that reported tag is clear. Every request gets exactly one response one cycle later.

Top module: `qtag_mem`

## Requirements
- R1: After reset every quadword's reported tag is 0, and `rsp_valid` is 0 while reset is held.
- R2: A store with size code 4 (16 bytes) writes all 128 bits of the quadword at `req_addr[ADDR_W-1:4]`. It sets every internal tag flop of that quadword to `req_tag`, whether 0 or 1.
- R3: A load (`req_we`=0) returns on the next cycle the 128-bit quadword together with `rsp_tag`. `rsp_tag` is the AND of all internal tag flops of that quadword. Byte k of the quadword sits on `rsp_rdata[8k+7:8k]`.
- R4: A store with size code 0, 1, 2 or 3 (1, 2, 4 or 8 bytes) writes the low 1, 2, 4 or 8 bytes of `req_wdata` into bytes starting at offset `req_addr[3:0]` of the quadword. All other bytes stay unchanged.
- R5: Any store with size code 0 to 3 clears all tag flops of the quadword it writes.
- R6: A load with `req_chk`=1 returns all-zero `rsp_rdata` when the quadword's tag is 0. It returns the stored data when the tag is 1. `rsp_tag` is reported in both cases.
- R7: A request is flagged with `rsp_align_err`=1 in either of two cases. The first is a load whose `req_addr[3:0]` is not 0. The second is a store whose size code is above 4, or whose address is not a multiple of its size. A flagged request changes no data and no tag, and returns zero data and tag 0.
- R8: Each request with `req_valid`=1 produces exactly one `rsp_valid` pulse on the next cycle, and no response appears without a request. A store response carries zero data and tag 0.
- R9: A store to one quadword leaves the data and tag of every other quadword unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_chk | input | 1 | Checked load: zero data when tag clear |
| req_size | input | 3 | Store size code: 0=1B, 1=2B, 2=4B, 3=8B, 4=16B |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 128 | Store data, narrow stores use the low bytes |
| req_tag | input | 1 | Tag written by a quadword store |
| rsp_valid | output | 1 | Response strobe, one cycle after request |
| rsp_rdata | output | 128 | Load data |
| rsp_tag | output | 1 | AND of the quadword's tag flops |
| rsp_align_err | output | 1 | Request rejected for alignment or size |

## Verification
The bench targets four kinds of error. A narrow store that keeps the tag would let a forged pointer pass, and a checked load after such a store would return non-zero data. A quadword store with tag 0 that does not clear an earlier set tag would show up as a stale tag of 1. Misaligned stores that still write, for example a halfword at an odd offset, would corrupt neighbouring bytes or clear a tag. Lane placement errors, such as the wrong offset or a write that spills into an adjacent quadword, are caught by a byte-exact reference model across a long random run.

// File: rtl/qtag_pkg.sv
package qtag_pkg;

  localparam int QW_BYTES = 16;
  localparam int QW_BITS  = 128;

  typedef enum logic [2:0] {
    SZ_B = 3'd0,
    SZ_H = 3'd1,
    SZ_W = 3'd2,
    SZ_D = 3'd3,
    SZ_Q = 3'd4
  } acc_size_e;

  // size code is legal when it names 1..16 bytes
  function automatic logic size_legal(input logic [2:0] sz);
    return sz <= 3'(SZ_Q);
  endfunction

  function automatic int unsigned size_bytes(input logic [2:0] sz);
    return 32'd1 << sz;
  endfunction

  // offset within quadword is a multiple of the access size
  function automatic logic off_aligned(input logic [3:0] off, input logic [2:0] sz);
    logic [3:0] m;
    m = 4'((size_bytes(sz)) - 1);
    return (off & m) == 4'd0;
  endfunction

  // one enable bit per byte lane covered by the access
  function automatic logic [QW_BYTES-1:0] lane_mask(input logic [3:0] off,
                                                    input logic [2:0] sz);
    logic [QW_BYTES-1:0] m;
    for (int k = 0; k < QW_BYTES; k++) begin
      m[k] = (k >= int'(off)) && (k < int'(off) + int'(size_bytes(sz)));
    end
    return m;
  endfunction

  // move the low bytes of the store data to their lane position
  function automatic logic [QW_BITS-1:0] place_data(input logic [QW_BITS-1:0] d,
                                                    input logic [3:0] off);
    return d << {off, 3'b000};
  endfunction

endpackage

// File: rtl/qtag_req_decode.sv
module qtag_req_decode
  import qtag_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 6
) (
  input  logic               req_valid,
  input  logic               req_we,
  input  logic [2:0]         req_size,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [QW_BITS-1:0] req_wdata,
  output logic [IDX_W-1:0]   idx,
  output logic [QW_BYTES-1:0] byte_en,
  output logic [QW_BITS-1:0] wdata_lane,
  output logic               wr_fire,
  output logic               rd_fire,
  output logic               is_qw,
  output logic               align_err
);
  logic [2:0] eff_size;
  logic [3:0] off;
  logic       bad;

  always_comb begin
    off        = req_addr[3:0];
    idx        = req_addr[ADDR_W-1:4];
    eff_size   = req_we ? req_size : 3'(SZ_Q);
    bad        = !size_legal(eff_size) || !off_aligned(off, eff_size);
    align_err  = req_valid && bad;
    wr_fire    = req_valid && req_we && !bad;
    rd_fire    = req_valid && !req_we && !bad;
    is_qw      = (eff_size == 3'(SZ_Q));
    byte_en    = lane_mask(off, eff_size);
    wdata_lane = place_data(req_wdata, off);
  end
endmodule

// File: rtl/qtag_tag_array.sv
module qtag_tag_array
  import qtag_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int GRAN_BYTES = 8,
  parameter int IDX_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic             is_qw,
  input  logic [IDX_W-1:0] idx,
  input  logic             tag_in,
  output logic [DEPTH-1:0] tag_and_vec
);
  localparam int TPQ = QW_BYTES / GRAN_BYTES;

  for (genvar q = 0; q < DEPTH; q++) begin : g_qw
    logic [TPQ-1:0] gran_q;
    for (genvar g = 0; g < TPQ; g++) begin : g_gran
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          gran_q[g] <= 1'b0;
        end else if (wr_fire && (idx == IDX_W'(q))) begin
          // quadword store copies the tag in, a narrow store clears it
          gran_q[g] <= is_qw ? tag_in : 1'b0;
        end
      end
    end
    assign tag_and_vec[q] = &gran_q;
  end
endmodule

// File: rtl/qtag_data_array.sv
module qtag_data_array
  import qtag_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input  logic                clk,
  input  logic                wr_fire,
  input  logic                rd_fire,
  input  logic [IDX_W-1:0]    idx,
  input  logic [QW_BYTES-1:0] byte_en,
  input  logic [QW_BITS-1:0]  wdata,
  output logic [QW_BITS-1:0]  rd_data
);
  logic [QW_BITS-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      for (int b = 0; b < QW_BYTES; b++) begin
        if (byte_en[b]) mem[idx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_fire) rd_data <= mem[idx];
  end
endmodule

// File: rtl/qtag_rsp.sv
module qtag_rsp
  import qtag_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_chk,
  input  logic               rd_fire,
  input  logic               align_err,
  input  logic               tag_now,
  input  logic [QW_BITS-1:0] rd_data,
  output logic               rsp_valid,
  output logic [QW_BITS-1:0] rsp_rdata,
  output logic               rsp_tag,
  output logic               rsp_align_err
);
  logic rd_q, pass_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_tag       <= 1'b0;
      rsp_align_err <= 1'b0;
      rd_q          <= 1'b0;
      pass_q        <= 1'b0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_align_err <= align_err;
      rd_q          <= rd_fire;
      rsp_tag       <= rd_fire && tag_now;
      // checked load hides data of an untagged quadword
      pass_q        <= rd_fire && (!req_chk || tag_now);
    end
  end

  assign rsp_rdata = (rd_q && pass_q) ? rd_data : '0;
endmodule

// File: rtl/qtag_mem.sv
module qtag_mem
  import qtag_pkg::*;
#(
  parameter int DEPTH      = 64,
  parameter int GRAN_BYTES = 8,
  parameter int IDX_W      = $clog2(DEPTH),
  parameter int ADDR_W     = IDX_W + 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_we,
  input  logic               req_chk,
  input  logic [2:0]         req_size,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [127:0]       req_wdata,
  input  logic               req_tag,
  output logic               rsp_valid,
  output logic [127:0]       rsp_rdata,
  output logic               rsp_tag,
  output logic               rsp_align_err
);
  logic [IDX_W-1:0]    wr_idx;
  logic [QW_BYTES-1:0] byte_en;
  logic [QW_BITS-1:0]  wdata_lane;
  logic                wr_fire, rd_fire, wr_is_qw, align_err_ev;
  logic [DEPTH-1:0]    tag_and_vec;
  logic [QW_BITS-1:0]  rd_data;
  logic                tag_now;

  qtag_req_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dec_i (
    .req_valid(req_valid), .req_we(req_we), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .idx(wr_idx),
    .byte_en(byte_en), .wdata_lane(wdata_lane), .wr_fire(wr_fire),
    .rd_fire(rd_fire), .is_qw(wr_is_qw), .align_err(align_err_ev)
  );

  qtag_tag_array #(.DEPTH(DEPTH), .GRAN_BYTES(GRAN_BYTES), .IDX_W(IDX_W)) tag_i (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .is_qw(wr_is_qw),
    .idx(wr_idx), .tag_in(req_tag), .tag_and_vec(tag_and_vec)
  );

  qtag_data_array #(.DEPTH(DEPTH), .IDX_W(IDX_W)) data_i (
    .clk(clk), .wr_fire(wr_fire), .rd_fire(rd_fire), .idx(wr_idx),
    .byte_en(byte_en), .wdata(wdata_lane), .rd_data(rd_data)
  );

  assign tag_now = tag_and_vec[wr_idx];

  qtag_rsp rsp_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_chk(req_chk),
    .rd_fire(rd_fire), .align_err(align_err_ev), .tag_now(tag_now),
    .rd_data(rd_data), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_tag(rsp_tag), .rsp_align_err(rsp_align_err)
  );
endmodule

// File: rtl/qtag_mem_chk.sv
module qtag_mem_chk #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_we,
  input logic             req_chk,
  input logic             req_tag,
  input logic             rsp_valid,
  input logic [127:0]     rsp_rdata,
  input logic             rsp_tag,
  input logic             rsp_align_err,
  input logic             wr_fire,
  input logic             wr_is_qw,
  input logic             align_err_ev,
  input logic [IDX_W-1:0] wr_idx,
  input logic [DEPTH-1:0] tag_and_vec
);
  p_rsp_follows_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_no_rsp_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  p_err_blocks_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    align_err_ev |-> !wr_fire);
  p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_align_err |-> (!rsp_tag && rsp_rdata == '0));
  p_chk_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we && req_chk) |=> (rsp_tag || rsp_rdata == '0));
  p_narrow_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && !wr_is_qw) |=> !tag_and_vec[$past(wr_idx)]);
  p_quad_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && wr_is_qw) |=> (tag_and_vec[$past(wr_idx)] == $past(req_tag)));
  p_store_rsp_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_we) |=> (!rsp_tag && rsp_rdata == '0));
endmodule

bind qtag_mem qtag_mem_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
  .req_chk(req_chk), .req_tag(req_tag), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag), .rsp_align_err(rsp_align_err),
  .wr_fire(wr_fire), .wr_is_qw(wr_is_qw), .align_err_ev(align_err_ev),
  .wr_idx(wr_idx), .tag_and_vec(tag_and_vec)
);

// File: tb/qtag_mem_tb_top.sv
module qtag_mem_tb_top;
  localparam int DEPTH  = 64;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int ADDR_W = IDX_W + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_chk = 1'b0, req_tag = 1'b0;
  logic [2:0] req_size = 3'd0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [127:0] req_wdata = '0;
  logic rsp_valid, rsp_tag, rsp_align_err;
  logic [127:0] rsp_rdata;

  always #10 clk = ~clk;  // 50 MHz

  qtag_mem #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_chk(req_chk), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_tag(req_tag), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag), .rsp_align_err(rsp_align_err)
  );

  typedef struct {
    logic [127:0] data;
    logic         tag;
    logic         err;
    int           due;
    string        req;
  } exp_t;

  exp_t sb[$];
  logic [127:0] m_data [DEPTH];
  logic         m_tag  [DEPTH];
  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // driver: computes the expected response from its own model and queues it
  task automatic drive(input logic we, input logic [2:0] sz, input int addr,
                       input logic [127:0] wd, input logic tg, input logic chk,
                       input string req);
    exp_t e;
    int q, off, n;
    bit err;
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_size = sz; req_addr = ADDR_W'(addr);
    req_wdata = wd; req_tag = tg; req_chk = chk;
    q = addr / 16; off = addr % 16;
    n = we ? (1 << sz) : 16;
    err = (we && sz > 3'd4) || (off % n != 0);
    e.data = '0; e.tag = 1'b0; e.err = err; e.due = cyc + 1; e.req = req;
    if (!err) begin
      if (we) begin
        for (int k = 0; k < n; k++) m_data[q][8*(off+k) +: 8] = wd[8*k +: 8];
        m_tag[q] = (n == 16) ? tg : 1'b0;
      end else begin
        e.tag  = m_tag[q];
        e.data = (chk && !m_tag[q]) ? 128'd0 : m_data[q];
      end
    end
    sb.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0; req_chk = 1'b0;
  endtask

  // monitor: pops the expected item in the cycle it falls due
  always @(negedge clk) begin
    if (rst_n) begin
      if (sb.size() > 0 && sb[0].due == cyc) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if (!rsp_valid || rsp_rdata !== e.data || rsp_tag !== e.tag ||
            rsp_align_err !== e.err) begin
          bad++;
          $display("FAIL %s: valid=%0d data=%h/%h tag=%0d/%0d err=%0d/%0d (actual/expected)",
                   e.req, rsp_valid, rsp_rdata, e.data, rsp_tag, e.tag, rsp_align_err, e.err);
        end
      end else if (rsp_valid) begin
        total++; bad++;
        $display("FAIL R8: unexpected response valid=1 expected=0");
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run hung actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [127:0] PA = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
  localparam logic [127:0] PB = 128'h11223344_55667788_99aabbcc_ddeeff00;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_tag[i] = 1'b0; end
    repeat (3) @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0) begin
      bad++; $display("FAIL R1: rsp_valid=%0d during reset expected=0", rsp_valid);
    end
    rst_n = 1'b1;
    // R1: every tag clear after reset (checked loads give zero data)
    for (int i = 0; i < DEPTH; i++) drive(1'b0, 3'd4, i*16, '0, 1'b0, 1'b1, "R1");
    // R2/R3/R6 tagged quadword
    drive(1'b1, 3'd4, 3*16, PA, 1'b1, 1'b0, "R8 store rsp");
    drive(1'b0, 3'd4, 3*16, '0, 1'b0, 1'b0, "R3 load tagged");
    drive(1'b0, 3'd4, 3*16, '0, 1'b0, 1'b1, "R6 chk tagged");
    // R2 quad store with tag 0 overwrites a set tag
    drive(1'b1, 3'd4, 5*16, PA, 1'b1, 1'b0, "R2 store");
    drive(1'b1, 3'd4, 5*16, PB, 1'b0, 1'b0, "R2 store");
    drive(1'b0, 3'd4, 5*16, '0, 1'b0, 1'b0, "R2 tag0 load");
    drive(1'b0, 3'd4, 5*16, '0, 1'b0, 1'b1, "R6 chk untagged");
    // R4/R5 narrow stores of each size
    drive(1'b1, 3'd0, 3*16+5, 128'h5a, 1'b1, 1'b0, "R5 byte");
    drive(1'b0, 3'd4, 3*16, '0, 1'b0, 1'b0, "R4 R5 byte load");
    drive(1'b0, 3'd4, 3*16, '0, 1'b0, 1'b1, "R5 R6 chk after byte");
    drive(1'b1, 3'd4, 7*16, PB, 1'b1, 1'b0, "R2 store");
    drive(1'b1, 3'd1, 7*16+6, 128'hbeef, 1'b1, 1'b0, "R5 half");
    drive(1'b0, 3'd4, 7*16, '0, 1'b0, 1'b0, "R4 R5 half load");
    drive(1'b1, 3'd4, 7*16, PA, 1'b1, 1'b0, "R2 store");
    drive(1'b1, 3'd2, 7*16+12, 128'hcafef00d, 1'b0, 1'b0, "R5 word");
    drive(1'b0, 3'd4, 7*16, '0, 1'b0, 1'b0, "R4 R5 word load");
    drive(1'b1, 3'd4, 7*16, PB, 1'b1, 1'b0, "R2 store");
    drive(1'b1, 3'd3, 7*16+8, 128'h0123456789abcdef, 1'b0, 1'b0, "R5 dword");
    drive(1'b0, 3'd4, 7*16, '0, 1'b0, 1'b0, "R4 R5 dword load");
    // R7 alignment and size errors
    drive(1'b1, 3'd4, 7*16, PA, 1'b1, 1'b0, "R2 store");
    drive(1'b1, 3'd4, 5*16+4, PA, 1'b1, 1'b0, "R7 misaligned quad");
    drive(1'b0, 3'd4, 5*16, '0, 1'b0, 1'b0, "R7 quad unchanged");
    drive(1'b1, 3'd1, 7*16+3, 128'hffff, 1'b0, 1'b0, "R7 odd half");
    drive(1'b1, 3'd5, 7*16, PB, 1'b0, 1'b0, "R7 size 5");
    drive(1'b1, 3'd2, 7*16+6, PB, 1'b0, 1'b0, "R7 word at 6");
    drive(1'b0, 3'd4, 7*16, '0, 1'b0, 1'b0, "R7 tag kept");
    drive(1'b0, 3'd4, 7*16+8, '0, 1'b0, 1'b0, "R7 misaligned load");
    // R9 neighbour isolation
    drive(1'b1, 3'd4, 8*16, PA, 1'b1, 1'b0, "R2 store");
    drive(1'b1, 3'd4, 9*16, PB, 1'b1, 1'b0, "R2 store");
    drive(1'b1, 3'd3, 8*16+8, 128'h77, 1'b0, 1'b0, "R5 dword");
    drive(1'b0, 3'd4, 9*16, '0, 1'b0, 1'b1, "R9 neighbour");
    drive(1'b0, 3'd4, 8*16, '0, 1'b0, 1'b0, "R9 R5 target");
    idle(); idle();
    // random mix over sixteen initialised quadwords
    for (int i = 0; i < 16; i++)
      drive(1'b1, 3'd4, i*16, {$urandom, $urandom, $urandom, $urandom}, 1'($urandom), 1'b0, "R2 init");
    for (int i = 0; i < 600; i++) begin
      int kind, sz, q;
      kind = $urandom % 4; q = $urandom % 16; sz = $urandom % 6;
      if (kind == 0)
        drive(1'b0, 3'd4, q*16 + (($urandom % 8 == 0) ? 4 : 0), '0, 1'b0, 1'($urandom),
              "R3 R6 R7 random load");
      else if (kind == 1)
        drive(1'b1, 3'd4, q*16, {$urandom, $urandom, $urandom, $urandom}, 1'($urandom), 1'b0,
              "R2 random quad");
      else if (kind == 2)
        drive(1'b1, 3'(sz), q*16 + ($urandom % 16), {$urandom, $urandom, $urandom, $urandom},
              1'($urandom), 1'b0, "R4 R5 R7 random store");
      else
        idle();
    end
    idle(); idle(); idle();
    total++;
    if (sb.size() != 0) begin
      bad++; $display("FAIL R8: %0d responses missing expected=0", sb.size());
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule